// File: doc/BRIEF.md
# Ethernet multicast hash filter

This block judges whether a received frame should be kept, based on its destination MAC address. The six address bytes arrive as a stream, one byte per accepted cycle, with a strobe on the first byte. While the bytes arrive, the block runs a serial Ethernet CRC-32 over them. One cycle after the sixth byte, it gives a registered pass/drop verdict, a multicast flag and a one-cycle valid strobe.

A small register window holds the filter controls. A control word carries three independent mode bits: accept everything, filter multicast by hash, and accept all multicast. The hash table's size is fixed at build time by a 2-bit size code: 64, 128 or 256 bins, stored as 32-bit words. A read-only capability word reports that size code to software.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, the control word and every hash word read as zero, and `dec_valid` stays low until a full address has been received.
- R2: The capability word at offset 0x04 returns the build-time size code `SZ` in bits 25:24 and zero in every other bit. Writes to it have no effect.
- R3: There are 2^SZ hash words, at offsets 0x10 + 4*i. Each can be written and read back in full. Offsets past the last word read as zero, and writes to them change no hash word.
- R4: The control word at offset 0x08 stores all 32 written bits and reads them back. Its mode bits are: bit 0 = accept all frames, bit 1 = hash multicast filtering, bit 2 = accept all multicast.
- R5: A byte with `byte_first` high starts a new address; any earlier partial address is dropped. Exactly one `dec_valid` pulse, one cycle wide, appears in the cycle after the edge that takes the sixth byte. Idle cycles between bytes are allowed.
- R6: The bin index is formed in three steps. First, a CRC-32 is run over the six bytes, least significant bit of each byte first, with the reflected polynomial 0xEDB88320 and a register that starts at all ones; the result is complemented. Second, that value is bit-reversed. Third, the index is its top 5+SZ bits. Index bits above bit 4 pick the hash word and bits 4:0 pick the bit in that word.
- R7: With bit 0 of the control word set, every address passes.
- R8: An address whose first byte has bit 0 clear is reported with `dec_mcast` = 0. It is dropped unless bit 0 of the control word is set.
- R9: The all-ones broadcast address passes whatever the mode bits and table contents are.
- R10: With bit 2 of the control word set, every group address passes.
- R11: With bit 2 clear and bit 1 set, a group address passes exactly when its hash bit is 1. With bits 0, 1 and 2 all clear, a non-broadcast group address is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` (combinational) |
| byte_valid | input | 1 | Address byte present |
| byte_first | input | 1 | Marks the first address byte |
| byte_data | input | 8 | Address byte, first byte first |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_pass | output | 1 | Verdict: 1 = keep the frame |
| dec_mcast | output | 1 | Address had the group bit set |

## Verification
A corrupted CRC register or a wrong index slice sends the lookup to the wrong bin. This is visible on the very next verdict: an address whose only table bit is set is dropped, or an address whose bit alone is cleared passes. The bench builds both tables for several addresses. A byte counter that slips moves or loses the `dec_valid` pulse, and the bench catches that within one cycle, both with idle gaps between bytes and with frames sent back to back. A wrongly decoded table word shows up on the first read of the register window.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int unsigned SZ = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [7:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        byte_valid,
  input  logic        byte_first,
  input  logic [7:0]  byte_data,
  output logic        dec_valid,
  output logic        dec_pass,
  output logic        dec_mcast
);
  localparam int unsigned NW = 1 << SZ;
  localparam int unsigned IW = 5 + SZ;
  localparam logic [7:0] A_FEAT = 8'h04;
  localparam logic [7:0] A_CTRL = 8'h08;
  localparam logic [7:0] A_HASH = 8'h10;

  logic [31:0] ctrl;
  logic [31:0] tbl [NW];
  logic [31:0] crc, crc_nx;
  logic [2:0]  cnt;
  logic        grp, bcast, bcast_nx, last, hit;
  logic [IW-1:0] idx;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  assign crc_nx   = crc_step(byte_first ? 32'hFFFFFFFF : crc, byte_data);
  assign bcast_nx = (byte_first | bcast) & (byte_data == 8'hFF);
  assign last     = byte_valid && !byte_first && cnt == 3'd5;

  always_comb begin
    for (int j = 0; j < int'(IW); j++) idx[IW-1-j] = ~crc_nx[j];
  end
  assign hit = tbl[idx[IW-1:5]][idx[4:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      for (int i = 0; i < int'(NW); i++) tbl[i] <= '0;
    end else if (csr_we) begin
      if (csr_addr == A_CTRL) ctrl <= csr_wdata;
      for (int i = 0; i < int'(NW); i++)
        if (csr_addr == 8'(A_HASH + 4 * i)) tbl[i] <= csr_wdata;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == A_FEAT) csr_rdata[25:24] = 2'(SZ);
    if (csr_addr == A_CTRL) csr_rdata = ctrl;
    for (int i = 0; i < int'(NW); i++)
      if (csr_addr == 8'(A_HASH + 4 * i)) csr_rdata = tbl[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; crc <= '0; grp <= 1'b0; bcast <= 1'b0;
      dec_valid <= 1'b0; dec_pass <= 1'b0; dec_mcast <= 1'b0;
    end else begin
      dec_valid <= last;
      if (byte_valid && byte_first) begin
        cnt <= 3'd1; crc <= crc_nx; grp <= byte_data[0]; bcast <= bcast_nx;
      end else if (byte_valid && cnt != 3'd0) begin
        cnt <= last ? 3'd0 : cnt + 3'd1;
        crc <= crc_nx; bcast <= bcast_nx;
      end
      if (last) begin
        dec_mcast <= grp;
        dec_pass  <= ctrl[0] | (grp & (bcast_nx | ctrl[2] | (ctrl[1] & hit)));
      end
    end
  end

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 3'd5);
  p_promisc_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(ctrl[0]) && $past(rst_n)) |-> dec_pass);
  p_unicast_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_mcast && !$past(ctrl[0])) |-> !dec_pass);
  p_pass_all_mc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_mcast && $past(ctrl[2]) && $past(rst_n)) |-> dec_pass);
endmodule

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
  localparam int SZ = 2;
  localparam int NW = 1 << SZ;
  localparam int IW = 5 + SZ;

  logic clk = 0, rst_n = 0;
  logic csr_we = 0;
  logic [7:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic byte_valid = 0, byte_first = 0;
  logic [7:0] byte_data = 0;
  logic dec_valid, dec_pass, dec_mcast;

  int checks = 0, fails = 0;
  logic [31:0] m_ctrl;
  logic [31:0] m_tbl [NW];
  logic [1:0] expq [$];

  mcast_hash_filter #(.SZ(SZ)) dut (.*);

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && dec_valid) begin
    if (expq.size() == 0) check("R5 unexpected verdict", 1, 0);
    else begin
      logic [1:0] e;
      e = expq.pop_front();
      check("R6-R11 verdict {mcast,pass}", {30'h0, dec_mcast, dec_pass}, {30'h0, e});
    end
  end

  function automatic logic [IW-1:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic [IW-1:0] r;
    c = '1;
    for (int n = 0; n < 48; n++) begin
      logic fb;
      fb = c[0] ^ a[47 - 8*(n/8) - 7 + (n%8)];
      c = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    c = ~c;
    for (int j = 0; j < IW; j++) r[IW-1-j] = c[j];
    return r;
  endfunction

  function automatic logic [1:0] ref_verdict(input logic [47:0] a);
    logic g, b, h, p;
    logic [IW-1:0] i;
    g = a[40];
    b = (a == 48'hFFFF_FFFF_FFFF);
    i = ref_idx(a);
    h = m_tbl[i >> 5][i[4:0]];
    p = m_ctrl[0] | (g & (b | m_ctrl[2] | (m_ctrl[1] & h)));
    return {g, p};
  endfunction

  task automatic csr_wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 0;
    if (a == 8'h08) m_ctrl = d;
    for (int i = 0; i < NW; i++) if (a == 8'(16 + 4*i)) m_tbl[i] = d;
  endtask

  task automatic csr_rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    csr_addr = a;
    @(negedge clk);
    d = csr_rdata;
  endtask

  task automatic send(input logic [47:0] a, input bit gaps, input bit timing);
    expq.push_back(ref_verdict(a));
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      byte_valid = 1; byte_first = (k == 0); byte_data = a[47-8*k -: 8];
      if (gaps && k < 5) begin
        @(posedge clk); #1;
        byte_valid = 0;
      end
    end
    @(posedge clk); #1;
    byte_valid = 0; byte_first = 0;
    if (timing) begin
      @(negedge clk);
      check("R5 valid one cycle after sixth byte", {31'h0, dec_valid}, 1);
      @(negedge clk);
      check("R5 valid single-cycle", {31'h0, dec_valid}, 0);
    end
  endtask

  task automatic load_one(input logic [IW-1:0] i, input bit invert);
    for (int w = 0; w < NW; w++) begin
      logic [31:0] v;
      v = (w == int'(i >> 5)) ? (32'h1 << i[4:0]) : 32'h0;
      csr_wr(8'(16 + 4*w), invert ? ~v : v);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [47:0] mc [3];
    m_ctrl = 0;
    for (int i = 0; i < NW; i++) m_tbl[i] = 0;
    mc[0] = 48'h01005E000001; mc[1] = 48'h3333000000FB; mc[2] = 48'h0180C2000000;

    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 no valid after reset", {31'h0, dec_valid}, 0);
    csr_rd(8'h08, d); check("R1 ctrl reset", d, 0);
    csr_rd(8'h10, d); check("R1 hash word 0 reset", d, 0);
    csr_rd(8'(16 + 4*(NW-1)), d); check("R1 last hash word reset", d, 0);

    csr_rd(8'h04, d); check("R2 capability code", d, 32'(SZ) << 24);
    csr_wr(8'h04, 32'hFFFF_FFFF);
    csr_rd(8'h04, d); check("R2 capability write ignored", d, 32'(SZ) << 24);

    for (int w = 0; w < NW; w++) csr_wr(8'(16 + 4*w), 32'hC0DE_0000 + 32'(w));
    for (int w = 0; w < NW; w++) begin
      csr_rd(8'(16 + 4*w), d); check("R3 hash word readback", d, 32'hC0DE_0000 + 32'(w));
    end
    csr_wr(8'(16 + 4*NW), 32'hDEAD_BEEF);
    csr_rd(8'(16 + 4*NW), d); check("R3 beyond-table reads zero", d, 0);
    csr_rd(8'h10, d); check("R3 beyond-table write no alias", d, 32'hC0DE_0000);
    for (int w = 0; w < NW; w++) csr_wr(8'(16 + 4*w), 0);

    csr_wr(8'h08, 32'h5A5A_0000);
    csr_rd(8'h08, d); check("R4 ctrl upper bits", d, 32'h5A5A_0000);
    csr_wr(8'h08, d | 32'h2);
    csr_rd(8'h08, d); check("R4 mode set keeps other bits", d, 32'h5A5A_0002);
    csr_wr(8'h08, 32'h5A5A_0000);

    send(48'h0012_3456_789A, 0, 1);              // R8 unicast dropped
    send(48'hFFFF_FFFF_FFFF, 0, 1);              // R9 broadcast, no modes
    send(mc[0], 0, 1);                           // R11 no modes drops
    csr_wr(8'h08, 32'h1);
    send(48'h0012_3456_789A, 1, 1);              // R7 promiscuous with gaps
    send(mc[1], 0, 1);                           // R7
    csr_wr(8'h08, 32'h4);
    send(mc[2], 0, 1);                           // R10
    send(48'h0200_0000_0001, 0, 1);              // R8 unicast under pass-all-mc
    csr_wr(8'h08, 32'h2);
    for (int m = 0; m < 3; m++) begin
      load_one(ref_idx(mc[m]), 0);
      send(mc[m], 0, 1);                         // R6 R11 only own bin set
      load_one(ref_idx(mc[m]), 1);
      send(mc[m], 1, 1);                         // R6 R11 own bin cleared
    end
    send(48'hFFFF_FFFF_FFFF, 0, 1);              // R9 broadcast, table mostly ones
    for (int w = 0; w < NW; w++) csr_wr(8'(16 + 4*w), 0);
    send(48'hFFFF_FFFF_FFFF, 0, 1);              // R9 broadcast, empty table
    load_one(ref_idx(mc[0]), 0);
    send(mc[0], 0, 0);                           // R5 back-to-back frames
    send(mc[1], 0, 0);
    send(mc[0], 0, 0);
    @(posedge clk); #1;
    byte_valid = 1; byte_first = 1; byte_data = 8'h01;   // R5 restart drops partial
    @(posedge clk); #1; byte_first = 0;
    send(mc[0], 0, 1);
    repeat (4) @(negedge clk);
    check("R5 queue drained", 32'(expq.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule